// File: doc/BRIEF.md
# Lockable Interrupt Aggregator

This block collects a parameterized set of interrupt request lines for one CPU and turns them into a single level signal for the CPU's external interrupt. Software controls it through a 32-bit word-addressed register port with byte strobes. The port gives access to a line mask, a pending word, and two alias words. A write to one alias clears pending bits and a write to the other sets them. Each input line is edge-detected, so a line held high produces exactly one request.

A global lock word defers interrupts. While the lock is set, requests on enabled lines are parked in a hidden wait set. Pending and the CPU output stay unchanged. When software writes 0 to the lock, the parked requests are merged into pending and the CPU output is raised. When software writes 1 to the lock while work is pending, the output is dropped.

The block also carries plain storage words that the interrupt software uses: a 64-bit handler address, a 64-bit debug cause, a 64-bit debug return address and a cause index. Each 64-bit value is written as two independent 32-bit halves. The register port never stalls. A write takes effect at the next clock edge. A read returns data one cycle after it is requested, together with a valid pulse.

Top module: `lock_irq_ctrl`

## Requirements
- R1: After reset the mask word reads 0xFFFFFFFF, the lock word reads 1, pending and all storage words read 0, and `cpu_irq_o` is 0.
- R2: Word offsets are mask 0, pending 1, clear alias 2, set alias 3, handler address low/high 4/5, debug cause low/high 6/7, debug return address low/high 8/9, lock 10 and cause index 11. The six storage halves and the cause index read back what was last written. Writing one half of a 64-bit value leaves the other half unchanged.
- R3: A mask bit of 0 enables its line. While the lock is 0, a rising edge on an enabled line sets pending bit n, and `cpu_irq_o` is 1 in the next cycle. A rising edge on a masked line changes nothing.
- R4: While the lock is 1, a rising edge on an enabled line changes neither pending nor `cpu_irq_o`. The request is held in an internal wait set.
- R5: A write of 0 (data bit 0 clear) to the lock word, when pending or the wait set is non-zero, ORs the wait set into pending, empties the wait set and sets `cpu_irq_o` to 1.
- R6: A write of 1 (data bit 0 set) to the lock word, when pending is non-zero, sets `cpu_irq_o` to 0.
- R7: A write to the clear alias replaces pending with pending AND NOT data. If this takes pending from non-zero to zero, `cpu_irq_o` becomes 0.
- R8: A write to the set alias ORs the data into pending. A write to the pending word replaces it. Neither write changes `cpu_irq_o`.
- R9: Reads of the clear and set aliases return 0. Reads of offsets 12 to 15 return 0xFFFFFFFF. The lock word reads as its bit 0 with all other bits 0. Reads change no state.
- R10: A write whose four strobe bits are all 0 is ignored. Any non-zero strobe writes the whole word.
- R11: A line held high for many cycles produces one request. After its pending bit is cleared, it is not set again until the line falls and rises.
- R12: `rd_valid_o` is 1 exactly one cycle after a read request (`acc_en_i`=1, `acc_wr_i`=0), and 0 in every other cycle. `rd_data_o` holds the value of the addressed word at the time of the request.
- R13: When a line edge and a register write fall in the same cycle, the edge is applied first and the write then acts on the updated state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lines_i | input | NLINES | Interrupt request lines, edge-detected |
| acc_en_i | input | 1 | Register access request, accepted every cycle |
| acc_wr_i | input | 1 | 1 for write, 0 for read |
| acc_ofs_i | input | 4 | Word offset |
| acc_wdata_i | input | 32 | Write data |
| acc_wstrb_i | input | 4 | Byte strobes; all zero skips the write |
| rd_data_o | output | 32 | Read data, one cycle after the request |
| rd_valid_o | output | 1 | Read data valid pulse |
| cpu_irq_o | output | 1 | Level interrupt to the CPU |

## Verification
Every effect of a line edge or a register write on `cpu_irq_o` and on the stored words appears one clock edge after the cycle that carries the stimulus. Read data and its valid pulse also arrive one edge after the request. The bench drives each stimulus on the falling edge. It advances its own model once per rising edge and compares the outputs 1 ns after that edge, so each result is checked in the cycle it is due. Register contents are checked with reads, whose data is compared against the model state captured in the request cycle.

// File: rtl/lirq_pkg.sv
`timescale 1ns/1ps
package lirq_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned STRB_W   = WORD_W / 8;
  localparam int unsigned OFS_W    = 4;
  localparam int unsigned NUM_REGS = 12;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [OFS_W-1:0]  ofs_t;

  // Word offsets of the register port.
  localparam ofs_t OFS_MASK = 4'd0;
  localparam ofs_t OFS_PEND = 4'd1;
  localparam ofs_t OFS_CLR  = 4'd2;
  localparam ofs_t OFS_SET  = 4'd3;
  localparam ofs_t OFS_HND0 = 4'd4;
  localparam ofs_t OFS_HND1 = 4'd5;
  localparam ofs_t OFS_DCS0 = 4'd6;
  localparam ofs_t OFS_DCS1 = 4'd7;
  localparam ofs_t OFS_DRA0 = 4'd8;
  localparam ofs_t OFS_DRA1 = 4'd9;
  localparam ofs_t OFS_LOCK = 4'd10;
  localparam ofs_t OFS_CIDX = 4'd11;

  // Storage halves occupy a contiguous run of offsets.
  localparam int unsigned STORE_BASE   = 4;
  localparam int unsigned STORE_HALVES = 6;

  typedef logic [NUM_REGS-1:0] wsel_t;
endpackage

// File: rtl/lirq_edge.sv
`timescale 1ns/1ps
module lirq_edge #(
  parameter int unsigned NLINES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NLINES-1:0] lvl_i,
  output logic [NLINES-1:0] rise_o
);
  logic [NLINES-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= '0;
    else         last_q <= lvl_i;
  end

  // One request per low-to-high transition of each line.
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    assign rise_o[g] = lvl_i[g] & ~last_q[g];
  end
endmodule

// File: rtl/lirq_core.sv
`timescale 1ns/1ps
module lirq_core import lirq_pkg::*; #(
  parameter int unsigned NLINES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NLINES-1:0] rise_i,
  input  wsel_t             wsel_i,
  input  word_t             wdata_i,
  output word_t             mask_o,
  output word_t             pend_o,
  output logic [NLINES-1:0] wait_o,
  output logic              lock_o,
  output logic              irq_o
);
  word_t             mask_q, mask_n;
  word_t             pend_q, pend_n, pend_pre;
  logic [NLINES-1:0] wait_q, wait_n, wait_pre;
  logic              lock_q, lock_n;
  logic              irq_q, irq_n, irq_pre;
  logic [NLINES-1:0] live_req;
  word_t             live_ext, wait_ext;

  always_comb begin
    // Stage 1: line events, routed by the current lock state.
    live_req = rise_i & ~mask_q[NLINES-1:0];
    live_ext = '0;
    live_ext[NLINES-1:0] = live_req;
    if (lock_q) begin
      pend_pre = pend_q;
      wait_pre = wait_q | live_req;
      irq_pre  = irq_q;
    end else begin
      pend_pre = pend_q | live_ext;
      wait_pre = wait_q;
      irq_pre  = irq_q | (|live_req);
    end
    wait_ext = '0;
    wait_ext[NLINES-1:0] = wait_pre;

    // Stage 2: the register write acts on the event-updated state.
    mask_n = mask_q;
    pend_n = pend_pre;
    wait_n = wait_pre;
    lock_n = lock_q;
    irq_n  = irq_pre;

    if (wsel_i[OFS_MASK]) mask_n = wdata_i;
    if (wsel_i[OFS_PEND]) pend_n = wdata_i;
    if (wsel_i[OFS_SET])  pend_n = pend_pre | wdata_i;
    if (wsel_i[OFS_CLR]) begin
      pend_n = pend_pre & ~wdata_i;
      if ((pend_pre != '0) && (pend_n == '0)) irq_n = 1'b0;
    end
    if (wsel_i[OFS_LOCK]) begin
      lock_n = wdata_i[0];
      if (!wdata_i[0]) begin
        if ((pend_pre | wait_ext) != '0) begin
          pend_n = pend_pre | wait_ext;
          wait_n = '0;
          irq_n  = 1'b1;
        end
      end else if (pend_pre != '0) begin
        irq_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      pend_q <= '0;
      wait_q <= '0;
      lock_q <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_n;
      pend_q <= pend_n;
      wait_q <= wait_n;
      lock_q <= lock_n;
      irq_q  <= irq_n;
    end
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;
  assign wait_o = wait_q;
  assign lock_o = lock_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/lirq_store.sv
`timescale 1ns/1ps
module lirq_store import lirq_pkg::*; (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [STORE_HALVES-1:0]              half_we_i,
  input  logic                                 cidx_we_i,
  input  word_t                                wdata_i,
  output logic [STORE_HALVES-1:0][WORD_W-1:0]  half_o,
  output word_t                                cidx_o
);
  logic [STORE_HALVES-1:0][WORD_W-1:0] half_q;
  word_t                               cidx_q;

  // Each 32-bit half has its own enable, so the sibling half is kept.
  for (genvar g = 0; g < STORE_HALVES; g++) begin : g_half
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           half_q[g] <= '0;
      else if (half_we_i[g]) half_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cidx_q <= '0;
    else if (cidx_we_i) cidx_q <= wdata_i;
  end

  assign half_o = half_q;
  assign cidx_o = cidx_q;
endmodule

// File: rtl/lock_irq_ctrl.sv
`timescale 1ns/1ps
module lock_irq_ctrl import lirq_pkg::*; #(
  parameter int unsigned NLINES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NLINES-1:0] irq_lines_i,
  input  logic              acc_en_i,
  input  logic              acc_wr_i,
  input  logic [OFS_W-1:0]  acc_ofs_i,
  input  logic [WORD_W-1:0] acc_wdata_i,
  input  logic [STRB_W-1:0] acc_wstrb_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              cpu_irq_o
);
  logic [NLINES-1:0]                   rise;
  logic                                wr_hit;
  logic                                rd_req;
  wsel_t                               wsel;
  word_t                               mask_q, pend_q, cidx_q;
  logic [NLINES-1:0]                   wait_q;
  logic                                lock_q;
  logic [STORE_HALVES-1:0][WORD_W-1:0] half_q;
  word_t                               rd_next, rd_data_q;
  logic                                rd_valid_q;

  assign wr_hit = acc_en_i & acc_wr_i & (|acc_wstrb_i) & (acc_ofs_i < OFS_W'(NUM_REGS));
  assign rd_req = acc_en_i & ~acc_wr_i;
  assign wsel   = wr_hit ? (wsel_t'(1) << acc_ofs_i) : '0;

  lirq_edge #(.NLINES(NLINES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (irq_lines_i),
    .rise_o (rise)
  );

  lirq_core #(.NLINES(NLINES)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (rise),
    .wsel_i  (wsel),
    .wdata_i (acc_wdata_i),
    .mask_o  (mask_q),
    .pend_o  (pend_q),
    .wait_o  (wait_q),
    .lock_o  (lock_q),
    .irq_o   (cpu_irq_o)
  );

  lirq_store u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .half_we_i (wsel[STORE_BASE +: STORE_HALVES]),
    .cidx_we_i (wsel[OFS_CIDX]),
    .wdata_i   (acc_wdata_i),
    .half_o    (half_q),
    .cidx_o    (cidx_q)
  );

  always_comb begin
    unique case (acc_ofs_i)
      OFS_MASK: rd_next = mask_q;
      OFS_PEND: rd_next = pend_q;
      OFS_CLR:  rd_next = '0;
      OFS_SET:  rd_next = '0;
      OFS_HND0: rd_next = half_q[0];
      OFS_HND1: rd_next = half_q[1];
      OFS_DCS0: rd_next = half_q[2];
      OFS_DCS1: rd_next = half_q[3];
      OFS_DRA0: rd_next = half_q[4];
      OFS_DRA1: rd_next = half_q[5];
      OFS_LOCK: rd_next = {{(WORD_W-1){1'b0}}, lock_q};
      OFS_CIDX: rd_next = cidx_q;
      default:  rd_next = '1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_req;
      if (rd_req) rd_data_q <= rd_next;
    end
  end

  assign rd_data_o  = rd_data_q;
  assign rd_valid_o = rd_valid_q;
endmodule

// File: rtl/lirq_chk.sv
`timescale 1ns/1ps
module lirq_chk import lirq_pkg::*; #(
  parameter int unsigned NLINES = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NLINES-1:0] irq_lines_i,
  input logic              acc_en_i,
  input logic              acc_wr_i,
  input logic [OFS_W-1:0]  acc_ofs_i,
  input logic              lock_bit_i,
  input logic [STRB_W-1:0] acc_wstrb_i,
  input logic              rd_valid_o,
  input logic              cpu_irq_o,
  input logic              lock_q,
  input word_t             pend_q,
  input word_t             mask_q,
  input logic [NLINES-1:0] wait_q
);
  logic [NLINES-1:0] seen_q;
  logic              wr_any, wr_clr, wr_lock, wr_pend_or_set, rd_req;
  logic [NLINES-1:0] live;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else         seen_q <= irq_lines_i;
  end

  assign live           = irq_lines_i & ~seen_q & ~mask_q[NLINES-1:0];
  assign wr_any         = acc_en_i && acc_wr_i && (acc_wstrb_i != '0);
  assign wr_clr         = wr_any && (acc_ofs_i == OFS_CLR);
  assign wr_lock        = wr_any && (acc_ofs_i == OFS_LOCK);
  assign wr_pend_or_set = wr_any && ((acc_ofs_i == OFS_PEND) || (acc_ofs_i == OFS_SET));
  assign rd_req         = acc_en_i && !acc_wr_i;

  a_r3_live_edge_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_q && (live != '0) && !wr_clr && !wr_lock) |=> cpu_irq_o);

  a_r4_locked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && !wr_any) |=> ($stable(cpu_irq_o) && $stable(pend_q)));

  a_r5_unlock_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lock && !lock_bit_i && ((pend_q != '0) || (wait_q != '0))) |=> (cpu_irq_o && (wait_q == '0)));

  a_r6_relock_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lock && lock_bit_i && (pend_q != '0)) |=> !cpu_irq_o);

  a_r7_clear_empty_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clr && (pend_q != '0)) |=> ((pend_q != '0) || !cpu_irq_o));

  a_r8_set_keeps_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && wr_pend_or_set) |=> $stable(cpu_irq_o));

  a_r10_zero_strobe_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_i && acc_wr_i && (acc_wstrb_i == '0) && (acc_ofs_i == OFS_MASK)) |=> $stable(mask_q));

  a_r12_read_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rd_valid_o);

  a_r12_no_spurious_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !rd_valid_o);
endmodule

bind lock_irq_ctrl lirq_chk #(.NLINES(NLINES)) u_lirq_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_lines_i (irq_lines_i),
  .acc_en_i    (acc_en_i),
  .acc_wr_i    (acc_wr_i),
  .acc_ofs_i   (acc_ofs_i),
  .lock_bit_i  (acc_wdata_i[0]),
  .acc_wstrb_i (acc_wstrb_i),
  .rd_valid_o  (rd_valid_o),
  .cpu_irq_o   (cpu_irq_o),
  .lock_q      (lock_q),
  .pend_q      (pend_q),
  .mask_q      (mask_q),
  .wait_q      (wait_q)
);

// File: tb/sim_lock_irq_ctrl.sv
`timescale 1ns/1ps
module sim_lock_irq_ctrl;
  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] lines = '0;
  logic          acc_en = 1'b0, acc_wr = 1'b0;
  logic [3:0]    acc_ofs = '0;
  logic [31:0]   acc_wdata = '0;
  logic [3:0]    acc_wstrb = '0;
  logic [31:0]   rd_data;
  logic          rd_valid, cpu_irq;

  always #2 clk = ~clk;

  lock_irq_ctrl #(.NLINES(NL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_lines_i(lines),
    .acc_en_i(acc_en), .acc_wr_i(acc_wr), .acc_ofs_i(acc_ofs),
    .acc_wdata_i(acc_wdata), .acc_wstrb_i(acc_wstrb),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .cpu_irq_o(cpu_irq)
  );

  // Reference state, built from the requirements.
  logic [31:0]   m_mask, m_pend, m_cidx;
  logic [31:0]   m_half [6];
  logic [NL-1:0] m_wait, m_prev;
  logic          m_lock, m_irq;
  int            nvec = 0, nbad = 0;
  string         phase = "R1";
  bit            done = 0;

  function automatic logic [31:0] exp_read(input logic [3:0] o);
    case (o)
      4'd0: return m_mask;
      4'd1: return m_pend;
      4'd2, 4'd3: return 32'h0;
      4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9: return m_half[o - 4'd4];
      4'd10: return {31'b0, m_lock};
      4'd11: return m_cidx;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic wr, input logic [3:0] o,
                      input logic [31:0] wd, input logic [3:0] st);
    logic [NL-1:0] er;
    logic [31:0]   p, old, rexp;
    logic [NL-1:0] w;
    logic          q, k, rd;
    acc_en = en; acc_wr = wr; acc_ofs = o; acc_wdata = wd; acc_wstrb = st;
    rd   = en && !wr;
    rexp = exp_read(o);
    er = lines & ~m_prev & ~m_mask[NL-1:0];
    p = m_pend; w = m_wait; q = m_irq; k = m_lock;
    if (k) w = w | er;
    else begin
      p = p | 32'(er);
      if (er != '0) q = 1'b1;
    end
    if (en && wr && st != 4'h0) begin
      case (o)
        4'd0: m_mask = wd;
        4'd1: p = wd;
        4'd2: begin old = p; p = p & ~wd; if (old != 0 && p == 0) q = 1'b0; end
        4'd3: p = p | wd;
        4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9: m_half[o - 4'd4] = wd;
        4'd10: begin
          k = wd[0];
          if (!wd[0]) begin
            if ((p | 32'(w)) != 0) begin p = p | 32'(w); w = '0; q = 1'b1; end
          end else if (p != 0) q = 1'b0;
        end
        4'd11: m_cidx = wd;
        default: ;
      endcase
    end
    m_prev = lines;
    @(posedge clk); #1;
    m_pend = p; m_wait = w; m_irq = q; m_lock = k;
    chk({phase, " irq"}, {31'b0, cpu_irq}, {31'b0, m_irq});
    chk("R12 rd_valid", {31'b0, rd_valid}, {31'b0, rd});
    if (rd) chk({phase, " rd_data"}, rd_data, rexp);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] o, input logic [31:0] d); step(1, 1, o, d, 4'hF); endtask
  task automatic rd(input logic [3:0] o); step(1, 0, o, 32'h0, 4'h0); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) step(0, 0, 4'h0, 32'h0, 4'h0); endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog R12 act=hung exp=finished");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    m_mask = '1; m_pend = '0; m_cidx = '0; m_wait = '0; m_prev = '0;
    m_lock = 1'b1; m_irq = 1'b0;
    for (int i = 0; i < 6; i++) m_half[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    phase = "R1 reset";
    chk("R1 irq at reset", {31'b0, cpu_irq}, 32'h0);
    for (int o = 0; o < 12; o++) if (o != 2 && o != 3) rd(4'(o));
    phase = "R9 alias/unmapped";
    rd(4'd2); rd(4'd3);
    for (int o = 12; o < 16; o++) rd(4'(o));

    phase = "R2 storage";
    for (int o = 4; o < 12; o++) wr(4'(o), 32'hA5A5_0000 + 32'(o));
    wr(4'd5, 32'h1234_5678);
    for (int o = 4; o < 12; o++) rd(4'(o));
    wr(4'd10, 32'hFFFF_FFFF);
    rd(4'd10);

    phase = "R10 zero strobe";
    step(1, 1, 4'd0, 32'h0, 4'h0);
    rd(4'd0);

    phase = "R3 enabled edge";
    wr(4'd10, 32'h0);
    wr(4'd0, ~32'h3);
    lines = 4'b0001; idle(1);
    rd(4'd1);
    phase = "R3 masked line";
    lines = 4'b0101; idle(1);
    rd(4'd1);

    phase = "R7 clear alias";
    wr(4'd2, 32'h1);
    rd(4'd1);

    phase = "R11 held line";
    lines = 4'b0111; idle(1);
    wr(4'd2, 32'h2);
    idle(5);
    rd(4'd1);

    phase = "R6 relock";
    lines = 4'b0000; idle(1);
    lines = 4'b0001; idle(1);
    wr(4'd10, 32'h1);

    phase = "R4 locked edge";
    lines = 4'b0000; idle(1);
    lines = 4'b0010; idle(2);
    rd(4'd1);

    phase = "R5 unlock";
    wr(4'd10, 32'h0);
    rd(4'd1);

    phase = "R8 set/direct";
    wr(4'd10, 32'h1);
    wr(4'd3, 32'h100);
    wr(4'd1, 32'h0);
    wr(4'd10, 32'h0);
    wr(4'd3, 32'h40);
    rd(4'd1);

    phase = "R13 same cycle";
    wr(4'd2, 32'hFFFF_FFFF);
    lines = 4'b0000; idle(1);
    lines = 4'b0001;
    wr(4'd2, 32'h1);
    rd(4'd1);

    phase = "random R3 R4 R5 R6 R7 R8";
    for (int i = 0; i < 4000; i++) begin
      logic [3:0]  o;
      logic [31:0] d;
      logic [3:0]  s;
      o = 4'($urandom % 16);
      if (($urandom % 3) == 0) o = 4'd10;
      d = $urandom;
      if (o == 4'd0) d = {28'hFFF_FFFF, 4'($urandom)};
      if (o == 4'd2 || o == 4'd3 || o == 4'd1) d = d & 32'h0000_00FF;
      s = (($urandom % 8) == 0) ? 4'h0 : 4'($urandom | 1);
      if (($urandom % 2) == 0) lines = 4'($urandom);
      step(($urandom % 3) != 0, ($urandom % 2) == 0, o, d, s);
    end
    for (int o = 0; o < 16; o++) rd(4'(o));

    done = 1;
    summary();
  end
endmodule